// File: doc/BRIEF.md
# Input Tap Change-Window Writer

This block performs guarded updates of a 5-bit receive sampling-tap select inside an interface PHY. A caller, such as a tuning sweep engine or a fixed-delay setup path, presents a new tap value together with a request. The block accepts the request, raises a change-window strobe and holds it for a settling period. It then loads the tap register, keeps the window high for a second settling period, and drops the window. After a third settling period it emits a one-cycle completion pulse. The tap register never moves outside an open window.

A separate tap-enable flag can be set or cleared at any time through two strobes. Software sets this flag before a tuning sweep starts. The flag has no effect on the update sequence. The length of each of the three steps is a parameter, so a slow analog delay line can be given longer settling holds.

Top module: `tap_window_writer`

## Requirements
- R1: After reset, chg_win and done are 0, req_ready is 1, tap_sel equals RESET_TAP (0 by default) and tap_en is 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle through the done cycle, and it returns to 1 in the cycle after done.
- R3: chg_win is 1 for exactly 2*HOLD_CYC consecutive cycles, starting in the cycle after acceptance.
- R4: tap_sel shows the accepted req_tap value starting in cycle HOLD_CYC+1 after acceptance (counting the first cycle after the accepting edge as cycle 1). Outside that load it keeps its old value.
- R5: tap_sel changes only in a cycle where chg_win is 1 and was also 1 in the previous cycle.
- R6: done is a single-cycle pulse in cycle 3*HOLD_CYC+1 after acceptance, so chg_win has been 0 for HOLD_CYC cycles when it appears.
- R7: A req_valid or req_tap presented while req_ready is 0 is ignored. The tap that is loaded is the one captured at acceptance, and no extra sequence follows.
- R8: tap_en becomes 0 in the cycle after ena_clr is 1, and becomes 1 in the cycle after ena_set is 1 while ena_clr is 0. When both are 1, the clear wins. Neither strobe alters tap_sel or the sequence timing.
- R9: All tap values from 0 to 2**TAP_W-1 (0 to 31 for TAP_W=5) are loaded unchanged, including both extremes.
- R10: If req_valid is held high continuously, the next request is accepted in the idle cycle that follows done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Update request |
| req_tap | input | TAP_W | New tap value, captured at acceptance |
| ena_set | input | 1 | Sets the tap-enable flag |
| ena_clr | input | 1 | Clears the tap-enable flag (wins over set) |
| req_ready | output | 1 | Block is idle and can accept a request |
| chg_win | output | 1 | Change window open |
| tap_sel | output | TAP_W | Registered tap select |
| tap_en | output | 1 | Tap-enable flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with TAP_W=5 and HOLD_CYC=2. With two cycles per step, the step counter actually counts, rather than firing on every cycle. That makes the window length, the load cycle and the done cycle distinguishable from the single-cycle default, and exposes off-by-one errors in each step. With a 5-bit tap, the full range of 32 values, including 0 and 31, is reachable by random and directed requests.

// File: rtl/tapw_pkg.sv
package tapw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_OPEN  = 3'd1,
        PH_WRITE = 3'd2,
        PH_CLOSE = 3'd3,
        PH_DONE  = 3'd4
    } phase_t;

    typedef struct packed {
        phase_t phase;
    } seq_state_t;

    function automatic logic phase_in_window(phase_t p);
        return (p == PH_OPEN) || (p == PH_WRITE);
    endfunction

endpackage

// File: rtl/tapw_step_timer.sv
module tapw_step_timer #(
    parameter int HOLD_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LAST_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last = (st_q.cnt == LAST_V);

    // R3
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

endmodule

// File: rtl/tapw_sequencer.sv
module tapw_sequencer
    import tapw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   step_last,
    output logic   step_restart,
    output logic   accept,
    output logic   wr_stb,
    output logic   ready,
    output logic   win,
    output logic   done
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        wr_stb = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    accept     = 1'b1;
                    st_d.phase = PH_OPEN;
                end
            end
            PH_OPEN: begin
                if (step_last) begin
                    wr_stb     = 1'b1;
                    st_d.phase = PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (step_last) st_d.phase = PH_CLOSE;
            end
            PH_CLOSE: begin
                if (step_last) st_d.phase = PH_DONE;
            end
            PH_DONE: begin
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
        step_restart = (st_d.phase != st_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = (st_q.phase == PH_IDLE);
    assign win   = phase_in_window(st_q.phase);
    assign done  = (st_q.phase == PH_DONE);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!win && $past(!win)));

    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> !ready);

    // R3
    win_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win) |-> $past(ready && req_valid));

endmodule

// File: rtl/tapw_tap_reg.sv
module tapw_tap_reg #(
    parameter int          TAP_W     = 5,
    parameter logic [TAP_W-1:0] RESET_TAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [TAP_W-1:0] req_tap,
    input  logic             wr_stb,
    input  logic             ena_set,
    input  logic             ena_clr,
    output logic [TAP_W-1:0] tap_q_o,
    output logic             en_q_o
);
    typedef struct packed {
        logic [TAP_W-1:0] pend;
        logic [TAP_W-1:0] tap;
        logic             en;
    } tap_state_t;

    tap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept) st_d.pend = req_tap;
        if (wr_stb) st_d.tap  = st_q.pend;
        if (ena_clr)      st_d.en = 1'b0;
        else if (ena_set) st_d.en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= RESET_TAP;
            st_q.tap  <= RESET_TAP;
            st_q.en   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tap_q_o = st_q.tap;
    assign en_q_o  = st_q.en;

    // R8
    en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ena_clr |=> !en_q_o);

    // R8
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_set && !ena_clr) |=> en_q_o);

endmodule

// File: rtl/tap_window_writer.sv
module tap_window_writer #(
    parameter int          TAP_W     = 5,
    parameter int          HOLD_CYC  = 1,
    parameter logic [TAP_W-1:0] RESET_TAP = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [TAP_W-1:0] req_tap,
    input  logic             ena_set,
    input  logic             ena_clr,
    output logic             req_ready,
    output logic             chg_win,
    output logic [TAP_W-1:0] tap_sel,
    output logic             tap_en,
    output logic             done
);
    logic step_last;
    logic step_restart;
    logic accept;
    logic wr_stb;

    tapw_step_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (step_restart),
        .last    (step_last)
    );

    tapw_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .step_last    (step_last),
        .step_restart (step_restart),
        .accept       (accept),
        .wr_stb       (wr_stb),
        .ready        (req_ready),
        .win          (chg_win),
        .done         (done)
    );

    tapw_tap_reg #(
        .TAP_W     (TAP_W),
        .RESET_TAP (RESET_TAP)
    ) u_tap (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .req_tap (req_tap),
        .wr_stb  (wr_stb),
        .ena_set (ena_set),
        .ena_clr (ena_clr),
        .tap_q_o (tap_sel),
        .en_q_o  (tap_en)
    );

    // R5
    tap_only_in_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap_sel) |-> (chg_win && $past(chg_win)));

    // R7
    no_write_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> $stable(tap_sel));

endmodule

// File: tb/sim_tap_window_writer.sv
module sim_tap_window_writer;
    localparam int TAP_W = 5;
    localparam int H     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [TAP_W-1:0] req_tap = '0;
    logic             ena_set = 1'b0;
    logic             ena_clr = 1'b0;
    logic             req_ready, chg_win, tap_en, done;
    logic [TAP_W-1:0] tap_sel;

    int total = 0;
    int bad   = 0;

    // model state
    bit m_busy = 0;
    int m_k    = 0;
    int m_tap  = 0;
    int m_pend = 0;
    bit m_en   = 0;

    always #2.5 clk = ~clk;

    tap_window_writer #(.TAP_W(TAP_W), .HOLD_CYC(H)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tap(req_tap),
        .ena_set(ena_set), .ena_clr(ena_clr), .req_ready(req_ready),
        .chg_win(chg_win), .tap_sel(tap_sel), .tap_en(tap_en), .done(done)
    );

    function automatic bit exp_win(bit busy, int k);
        return busy && (k >= 1) && (k <= 2*H);
    endfunction

    function automatic bit exp_done(bit busy, int k);
        return busy && (k == 3*H + 1);
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // model update at a clock edge, from the inputs driven before it
    task automatic model_edge();
        if (!m_busy) begin
            if (req_valid) begin
                m_busy = 1;
                m_k    = 1;
                m_pend = int'(req_tap);
            end
        end else begin
            m_k++;
            if (m_k == H + 1) m_tap = m_pend;
            if (m_k == 3*H + 2) m_busy = 0;
        end
        if (ena_clr)      m_en = 0;
        else if (ena_set) m_en = 1;
    endtask

    // one cycle: inputs already set at negedge; edge; check at next negedge
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 req_ready", int'(req_ready), int'(!m_busy));
        chk("R3 chg_win",   int'(chg_win),   int'(exp_win(m_busy, m_k)));
        chk("R4/R5 tap_sel", int'(tap_sel),  m_tap);
        chk("R6 done",      int'(done),      int'(exp_done(m_busy, m_k)));
        chk("R8 tap_en",    int'(tap_en),    int'(m_en));
    endtask

    task automatic drive(bit v, int t, bit s, bit c);
        req_valid = v;
        req_tap   = TAP_W'(t);
        ena_set   = s;
        ena_clr   = c;
    endtask

    task automatic do_update(int t);
        drive(1, t, 0, 0);
        cycle();
        drive(0, 0, 0, 0);
        for (int i = 0; i < 3*H + 1; i++) cycle();
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5a17));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 chg_win", int'(chg_win), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 req_ready", int'(req_ready), 1);
        chk("R1 tap_sel", int'(tap_sel), 0);
        chk("R1 tap_en", int'(tap_en), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 extremes
        do_update(31);
        chk("R9 tap 31", int'(tap_sel), 31);
        do_update(0);
        chk("R9 tap 0", int'(tap_sel), 0);
        do_update(17);

        // R7 requests while busy are ignored
        drive(1, 9, 0, 0);
        cycle();
        for (int i = 0; i < 3*H + 1; i++) begin
            drive(1, 22 + i, 0, 0);
            if (i == 3*H) drive(0, 3, 0, 0);
            cycle();
        end
        chk("R7 tap kept", int'(tap_sel), 9);
        drive(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cycle();
        chk("R7 no extra seq", int'(tap_sel), 9);

        // R10 held request, back to back
        drive(1, 5, 0, 0);
        for (int i = 0; i < 3*(3*H + 2); i++) begin
            req_tap = TAP_W'(5 + i);
            cycle();
        end
        drive(0, 0, 0, 0);
        for (int i = 0; i < 3*H + 3; i++) cycle();

        // R8 set, clear, both
        drive(0, 0, 1, 0); cycle();
        chk("R8 set", int'(tap_en), 1);
        drive(0, 0, 1, 1); cycle();
        chk("R8 clear wins", int'(tap_en), 0);
        drive(1, 12, 1, 0); cycle();
        drive(0, 0, 0, 0);
        for (int i = 0; i < 3*H + 2; i++) cycle();
        chk("R8 no effect on tap", int'(tap_sel), 12);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            drive(($urandom % 3) == 0, int'($urandom % 32),
                  ($urandom % 8) == 0, ($urandom % 10) == 0);
            cycle();
        end
        drive(0, 0, 0, 0);
        for (int i = 0; i < 3*H + 3; i++) cycle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule